// File: doc/BRIEF.md
# Parallel Head/Tail Instruction Extractor

This block takes one fixed-size instruction bundle and recovers up to eight instructions from it at once. The bundle stores every instruction as two parts. The first is a fixed-width head. Heads are placed one after another at the top of the bundle, directly under a small count field. The second is a variable-length tail, made of whole 5-bit units. Tails fill the bundle upward from bit 0, so the first instruction's tail sits at the very bottom.

Every head is at a known bit position, so all heads have their tail length looked up at the same time. The lookup uses a 4-bit opcode and a parameter table. The only serial logic is a short running-sum chain of tail lengths. That chain gives each tail's start offset, and each tail is then shifted down to bit 0.

A bundle is flagged as malformed in two cases. One is when its heads and tails together need more bits than the bundle has. The other is when its count names a slot beyond the last one. When either happens, every slot is dropped. The results pass through one output register stage, which can be selected by a parameter and is on by default.

Top module: `hat_extract`

## Requirements
- R1: Bits [127:124] of the bundle hold the index of the last instruction. For a well-formed bundle, slots 0 up to that index are valid and all higher slots are invalid, so the valid mask is always a contiguous run starting at slot 0.
- R2: Head i occupies bundle bits [123-10*i -: 10]. A valid slot outputs this 10-bit head unchanged on `slot_head_o[10*i +: 10]`.
- R3: The opcode is bits [9:6] of the head. The tail length in units is `LEN_TABLE[3*opcode +: 3]`. The default table gives opcode k a length of (k mod 6)+1, which is always in the range 1 to 6. A valid slot reports this length on `slot_len_o[3*i +: 3]`.
- R4: Tail 0 starts at bundle bit 0. Tail i starts at bit 5 times the sum of the lengths of tails 0 to i-1. A valid slot outputs its tail on `slot_tail_o[30*i +: 30]`, with the tail's first bit at bit 0 and every bit above 5*length equal to zero.
- R5: `malformed_o` is set, and every slot is invalid, when 4 + 10*(last+1) + 5*(sum of the in-use tail lengths) is greater than 128. It is also set when the last index is 8 or more. A total of exactly 124 bits is accepted.
- R6: An invalid slot drives zero on its head, length and tail outputs.
- R7: Bundle bits that are covered by neither the count field, a used head, nor a used tail have no effect on any output.
- R8: With the default single register stage, the outputs show the bundle sampled at the previous rising clock edge. An active-low `rst_n` clears every output to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| bundle_i | input | 128 | Instruction bundle |
| slot_valid_o | output | 8 | Valid flag for each slot; bit i is slot i |
| slot_head_o | output | 80 | Heads; slot i is in bits [10*i +: 10] |
| slot_len_o | output | 24 | Tail lengths in units; slot i is in bits [3*i +: 3] |
| slot_tail_o | output | 240 | Tails shifted down to bit 0; slot i is in bits [30*i +: 30] |
| malformed_o | output | 1 | The bundle overflows or names too many slots |

## Verification
The assertions on length range and tail width rely on one assumption: every entry of the length table is between 1 and 6. With that assumption, a valid slot always has a non-zero tail of at most six units. The default table meets it, and the stimulus uses only the default table. The bench builds each bundle from a last index and per-slot opcodes, and computes tail placement from its own copy of the length rule. It uses both well-formed and overflowing counts. Every vector is applied twice, once with the unused gap bits cleared and once with them set, so the other checks also show that the gap bits are ignored.

// File: rtl/hat_pkg.sv
package hat_pkg;

  localparam int DEF_OPC_W     = 4;
  localparam int DEF_LEN_W     = 3;
  localparam int DEF_MAX_UNITS = 6;
  localparam int DEF_TABLE_W   = (1 << DEF_OPC_W) * DEF_LEN_W;

  // Default opcode-to-length table: opcode k -> (k mod 6) + 1 units.
  function automatic logic [DEF_TABLE_W-1:0] default_len_table();
    logic [DEF_TABLE_W-1:0] t;
    t = '0;
    for (int k = 0; k < (1 << DEF_OPC_W); k++) begin
      t[k*DEF_LEN_W +: DEF_LEN_W] = DEF_LEN_W'((k % DEF_MAX_UNITS) + 1);
    end
    return t;
  endfunction

endpackage

// File: rtl/hat_len_decode.sv
module hat_len_decode #(
  parameter int OPC_W = 4,
  parameter int LEN_W = 3,
  parameter logic [(1<<OPC_W)*LEN_W-1:0] LEN_TABLE = '0
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic [LEN_W-1:0] len_o
);

  always_comb begin
    len_o = LEN_TABLE[opcode_i*LEN_W +: LEN_W];
  end

endmodule

// File: rtl/hat_tail_offset.sv
module hat_tail_offset #(
  parameter int BUNDLE_W = 128,
  parameter int CNT_W    = 4,
  parameter int HEAD_W   = 10,
  parameter int UNIT_W   = 5,
  parameter int LEN_W    = 3,
  parameter int N_SLOTS  = 8,
  parameter int OFF_W    = 6
) (
  input  logic [CNT_W-1:0]         last_i,
  input  logic [N_SLOTS*LEN_W-1:0] lens_i,
  output logic [N_SLOTS*OFF_W-1:0] offs_o,
  output logic                     malformed_o
);

  // Running sum of tail lengths of the slots in use; acc[i] is slot i's offset.
  logic [OFF_W-1:0] acc [N_SLOTS+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chain
    logic in_use;
    assign in_use    = (int'(last_i) >= i);
    assign acc[i+1]  = acc[i] + (in_use ? OFF_W'(lens_i[i*LEN_W +: LEN_W]) : '0);
    assign offs_o[i*OFF_W +: OFF_W] = acc[i];
  end

  always_comb begin
    int need;
    need = CNT_W + HEAD_W * (int'(last_i) + 1) + UNIT_W * int'(acc[N_SLOTS]);
    malformed_o = (int'(last_i) >= N_SLOTS) || (need > BUNDLE_W);
  end

endmodule

// File: rtl/hat_tail_align.sv
module hat_tail_align #(
  parameter int BUNDLE_W  = 128,
  parameter int UNIT_W    = 5,
  parameter int LEN_W     = 3,
  parameter int MAX_UNITS = 6,
  parameter int OFF_W     = 6,
  localparam int TAIL_W   = UNIT_W * MAX_UNITS
) (
  input  logic [BUNDLE_W-1:0] bundle_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [TAIL_W-1:0]   tail_o
);

  logic [BUNDLE_W-1:0] shifted;

  always_comb begin
    shifted = bundle_i >> (UNIT_W * int'(off_i));
  end

  for (genvar u = 0; u < MAX_UNITS; u++) begin : g_unit
    assign tail_o[u*UNIT_W +: UNIT_W] =
      (u < int'(len_i)) ? shifted[u*UNIT_W +: UNIT_W] : '0;
  end

endmodule

// File: rtl/hat_out_stage.sv
module hat_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_q;
    logic [W-1:0] q_d;
    logic         q_en;

    always_comb begin
      q_en = 1'b1;
      q_d  = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_q <= '0;
      end else if (q_en) begin
        q_q <= q_d;
      end
    end

    assign q_o = q_q;
  end else begin : g_comb
    assign q_o = d_i;
  end

endmodule

// File: rtl/hat_extract.sv
module hat_extract #(
  parameter int BUNDLE_W  = 128,
  parameter int CNT_W     = 4,
  parameter int HEAD_W    = 10,
  parameter int OPC_W     = 4,
  parameter int UNIT_W    = 5,
  parameter int LEN_W     = 3,
  parameter int MAX_UNITS = 6,
  parameter int N_SLOTS   = 8,
  parameter bit REG_OUT   = 1'b1,
  parameter logic [(1<<OPC_W)*LEN_W-1:0] LEN_TABLE = hat_pkg::default_len_table(),
  localparam int TAIL_W   = UNIT_W * MAX_UNITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BUNDLE_W-1:0]       bundle_i,
  output logic [N_SLOTS-1:0]        slot_valid_o,
  output logic [N_SLOTS*HEAD_W-1:0] slot_head_o,
  output logic [N_SLOTS*LEN_W-1:0]  slot_len_o,
  output logic [N_SLOTS*TAIL_W-1:0] slot_tail_o,
  output logic                      malformed_o
);

  localparam int TOT_UNITS = N_SLOTS * MAX_UNITS;
  localparam int OFF_W     = $clog2(TOT_UNITS + 1);
  localparam int HEAD_TOP  = BUNDLE_W - CNT_W - 1;
  localparam int OUT_W     = N_SLOTS * (1 + HEAD_W + LEN_W + TAIL_W) + 1;

  logic [CNT_W-1:0]         last_idx;
  logic [N_SLOTS*LEN_W-1:0] lens;
  logic [N_SLOTS*OFF_W-1:0] offs;
  logic                     bad_c;

  logic [N_SLOTS-1:0]        valid_c;
  logic [N_SLOTS*HEAD_W-1:0] head_c;
  logic [N_SLOTS*LEN_W-1:0]  len_c;
  logic [N_SLOTS*TAIL_W-1:0] tail_c;

  assign last_idx = bundle_i[BUNDLE_W-1 -: CNT_W];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic [HEAD_W-1:0] head;
    logic [LEN_W-1:0]  len;
    logic [TAIL_W-1:0] tail;

    assign head = bundle_i[HEAD_TOP - i*HEAD_W -: HEAD_W];

    hat_len_decode #(
      .OPC_W    (OPC_W),
      .LEN_W    (LEN_W),
      .LEN_TABLE(LEN_TABLE)
    ) i_len (
      .opcode_i(head[HEAD_W-1 -: OPC_W]),
      .len_o   (len)
    );

    assign lens[i*LEN_W +: LEN_W] = len;

    hat_tail_align #(
      .BUNDLE_W (BUNDLE_W),
      .UNIT_W   (UNIT_W),
      .LEN_W    (LEN_W),
      .MAX_UNITS(MAX_UNITS),
      .OFF_W    (OFF_W)
    ) i_align (
      .bundle_i(bundle_i),
      .off_i   (offs[i*OFF_W +: OFF_W]),
      .len_i   (len),
      .tail_o  (tail)
    );

    assign valid_c[i] = !bad_c && (int'(last_idx) >= i);
    assign head_c[i*HEAD_W +: HEAD_W] = valid_c[i] ? head : '0;
    assign len_c[i*LEN_W +: LEN_W]    = valid_c[i] ? len  : '0;
    assign tail_c[i*TAIL_W +: TAIL_W] = valid_c[i] ? tail : '0;
  end

  hat_tail_offset #(
    .BUNDLE_W(BUNDLE_W),
    .CNT_W   (CNT_W),
    .HEAD_W  (HEAD_W),
    .UNIT_W  (UNIT_W),
    .LEN_W   (LEN_W),
    .N_SLOTS (N_SLOTS),
    .OFF_W   (OFF_W)
  ) i_offset (
    .last_i     (last_idx),
    .lens_i     (lens),
    .offs_o     (offs),
    .malformed_o(bad_c)
  );

  hat_out_stage #(
    .W      (OUT_W),
    .REG_OUT(REG_OUT)
  ) i_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({valid_c, head_c, len_c, tail_c, bad_c}),
    .q_o  ({slot_valid_o, slot_head_o, slot_len_o, slot_tail_o, malformed_o})
  );

endmodule

// File: rtl/hat_extract_chk.sv
module hat_extract_chk #(
  parameter int HEAD_W    = 10,
  parameter int UNIT_W    = 5,
  parameter int LEN_W     = 3,
  parameter int MAX_UNITS = 6,
  parameter int N_SLOTS   = 8,
  localparam int TAIL_W   = UNIT_W * MAX_UNITS
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_SLOTS-1:0]        slot_valid_o,
  input logic [N_SLOTS*HEAD_W-1:0] slot_head_o,
  input logic [N_SLOTS*LEN_W-1:0]  slot_len_o,
  input logic [N_SLOTS*TAIL_W-1:0] slot_tail_o,
  input logic                      malformed_o
);

  // Valid slots form a contiguous run from slot 0.
  assert_prefix_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({1'b0, slot_valid_o} + (N_SLOTS+1)'(1)) == 1);

  assert_malformed_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    malformed_o |-> (slot_valid_o == '0));

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid_o[i] |-> (slot_head_o[i*HEAD_W +: HEAD_W] == '0 &&
                            slot_len_o[i*LEN_W +: LEN_W] == '0 &&
                            slot_tail_o[i*TAIL_W +: TAIL_W] == '0));

    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[i] |-> (int'(slot_len_o[i*LEN_W +: LEN_W]) >= 1 &&
                           int'(slot_len_o[i*LEN_W +: LEN_W]) <= MAX_UNITS));

    assert_tail_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid_o[i] |-> ((slot_tail_o[i*TAIL_W +: TAIL_W] >>
                            (UNIT_W * int'(slot_len_o[i*LEN_W +: LEN_W]))) == '0));
  end

endmodule

bind hat_extract hat_extract_chk #(
  .HEAD_W   (HEAD_W),
  .UNIT_W   (UNIT_W),
  .LEN_W    (LEN_W),
  .MAX_UNITS(MAX_UNITS),
  .N_SLOTS  (N_SLOTS)
) i_hat_extract_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_valid_o(slot_valid_o),
  .slot_head_o (slot_head_o),
  .slot_len_o  (slot_len_o),
  .slot_tail_o (slot_tail_o),
  .malformed_o (malformed_o)
);

// File: tb/test_hat_extract.sv
module test_hat_extract;

  typedef struct packed {
    logic [3:0]  last;
    logic [31:0] ops;   // slot i opcode in ops[4*i +: 4]
    logic        bad;
  } vec_t;

  localparam int N_VEC = 10;
  localparam vec_t VECS [N_VEC] = '{
    '{4'd0,  32'h00000000, 1'b0},
    '{4'd2,  32'h00000315, 1'b0},
    '{4'd7,  32'h00000000, 1'b0},  // 124 bits: fits
    '{4'd7,  32'h00001000, 1'b1},  // 129 bits
    '{4'd3,  32'h00000255, 1'b0},  // 124 bits: fits
    '{4'd3,  32'h00000355, 1'b1},  // 129 bits
    '{4'd8,  32'h00000000, 1'b1},  // index past last slot
    '{4'd15, 32'h00000000, 1'b1},
    '{4'd5,  32'h0066FEDC, 1'b0},
    '{4'd1,  32'h000000A9, 1'b0}
  };

  logic         clk;
  logic         rst_n;
  logic [127:0] bundle;
  logic [7:0]   slot_valid;
  logic [79:0]  slot_head;
  logic [23:0]  slot_len;
  logic [239:0] slot_tail;
  logic         malformed;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  hat_extract i_hat_extract (
    .clk         (clk),
    .rst_n       (rst_n),
    .bundle_i    (bundle),
    .slot_valid_o(slot_valid),
    .slot_head_o (slot_head),
    .slot_len_o  (slot_len),
    .slot_tail_o (slot_tail),
    .malformed_o (malformed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Length rule from R3 (default table).
  function automatic int exp_len(input logic [3:0] op);
    return (int'(op) % 6) + 1;
  endfunction

  function automatic logic [29:0] tail_val(input int vi, input int i);
    return 30'h2B5A_C3E1 ^ 30'(vi << 9) ^ 30'(i * 30'h0131_0F27);
  endfunction

  function automatic logic [9:0] head_val(input vec_t v, input int vi, input int i);
    return {v.ops[4*i +: 4], 6'(vi * 8 + i)};
  endfunction

  function automatic logic [127:0] build(input vec_t v, input int vi, input bit gap);
    logic [127:0] b;
    int off;
    b = gap ? '1 : '0;
    off = 0;
    b[127:124] = v.last;
    for (int i = 0; i < 8 && i <= int'(v.last); i++) begin
      int len;
      logic [29:0] tv;
      b[123 - 10*i -: 10] = head_val(v, vi, i);
      len = exp_len(v.ops[4*i +: 4]);
      tv  = tail_val(vi, i);
      for (int u = 0; u < len * 5; u++) begin
        if (off * 5 + u < 128) b[off*5 + u] = tv[u];
      end
      off += len;
    end
    return b;
  endfunction

  task automatic check_vec(input vec_t v, input int vi, input string tag);
    logic [7:0] exp_mask;
    exp_mask = v.bad ? 8'h00 : 8'((1 << (int'(v.last) + 1)) - 1);
    chk(malformed == v.bad, "R5", {tag, " malformed"}, 64'(malformed), 64'(v.bad));
    chk(slot_valid == exp_mask, "R1", {tag, " valid mask"}, 64'(slot_valid), 64'(exp_mask));
    for (int i = 0; i < 8; i++) begin
      if (exp_mask[i]) begin
        int len;
        logic [29:0] et;
        len = exp_len(v.ops[4*i +: 4]);
        et  = tail_val(vi, i) & 30'((64'd1 << (5*len)) - 1);
        chk(slot_head[10*i +: 10] == head_val(v, vi, i), "R2", {tag, " head"},
            64'(slot_head[10*i +: 10]), 64'(head_val(v, vi, i)));
        chk(int'(slot_len[3*i +: 3]) == len, "R3", {tag, " len"},
            64'(slot_len[3*i +: 3]), 64'(len));
        chk(slot_tail[30*i +: 30] == et, "R4", {tag, " tail"},
            64'(slot_tail[30*i +: 30]), 64'(et));
      end else begin
        chk(slot_head[10*i +: 10] == '0 && slot_len[3*i +: 3] == '0 &&
            slot_tail[30*i +: 30] == '0, "R6", {tag, " invalid slot zero"},
            64'(slot_tail[30*i +: 30]), 64'(0));
      end
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    bundle = build(VECS[1], 1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slot_valid == '0 && slot_head == '0 && slot_len == '0 &&
        slot_tail == '0 && malformed == 1'b0, "R8", "outputs in reset",
        64'(slot_valid), 64'(0));
    rst_n = 1'b1;

    // Table walk; pass 1 sets every unused gap bit (R7).
    for (int pass = 0; pass < 2; pass++) begin
      for (int vi = 0; vi < N_VEC; vi++) begin
        @(negedge clk);
        bundle = build(VECS[vi], vi, pass[0]);
        @(posedge clk);
        @(negedge clk);
        check_vec(VECS[vi], vi, pass == 0 ? "gap0" : "gap1 R7");
      end
    end

    // R8: one-cycle latency.
    @(negedge clk);
    bundle = build(VECS[2], 2, 1'b0);
    @(posedge clk);
    @(negedge clk);
    bundle = build(VECS[0], 0, 1'b1);
    #1;
    chk(slot_valid == 8'hFF, "R8", "output holds before edge", 64'(slot_valid), 64'hFF);
    @(posedge clk);
    @(negedge clk);
    chk(slot_valid == 8'h01, "R8", "output updates after edge", 64'(slot_valid), 64'h01);

    // R8: asynchronous clear mid-cycle.
    #2;
    rst_n = 1'b0;
    #1;
    chk(slot_valid == '0 && slot_head == '0 && slot_tail == '0, "R8",
        "async clear", 64'(slot_valid), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_vec(VECS[0], 0, "after reset R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule